// File: doc/BRIEF.md
# Half-Rate Quadrature Bang-Bang Phase Detector

This block sits at the front of a half-rate clock and data recovery loop. A clock at half the bit rate and a copy of it shifted by a quarter period both sample the serial line on their rising and falling edges. The in-phase clock takes samples at the bit centres, so each clock period carries two data bits. The quadrature clock takes samples at the bit boundaries, one between each pair of neighbouring bits. The in-phase samples are split straight away into an even-bit stream and an odd-bit stream.

Each bit boundary gives three consecutive samples: the centre of the earlier bit (S0), the boundary (S1) and the centre of the later bit (S2). From these the block decides whether the recovered clock is early or late for that transition. It also reports when there is nothing to decide, because the line did not change or the samples contradict each other.

Both data bits of one clock period and both of its decisions are registered together on the rising edge of the in-phase clock. A loop filter or charge-pump model outside this block can therefore read one lane per bit slot.

Top module: `hrpd_top`

## Requirements
- R1: While `rst_n` is low at rising edges of `clk0`, all outputs are 0 after those edges.
- R2: The sample taken at a `clk0` rising edge appears on `bit_even`, and the sample at the following `clk0` falling edge appears on `bit_odd`. Both appear together after the second `clk0` rising edge that follows the even sample.
- R3: Lane 0 of `early`, `late` and `valid` judges the transition from the even bit to the odd bit of the same period, using the `clk90` rising-edge sample as S1. Lane 1 judges the transition from that odd bit to the next even bit, using the `clk90` falling-edge sample as S1.
- R4: When S0 equals S1 and S1 differs from S2, the lane shows early=1, late=0, valid=1.
- R5: When S0 differs from S1 and S1 equals S2, the lane shows early=0, late=1, valid=1.
- R6: When S0, S1 and S2 are all equal (no transition), the lane shows early, late and valid all 0.
- R7: When S0 equals S2 but S1 differs from both (a glitch at the boundary), the lane shows early, late and valid all 0.
- R8: In each lane, early and late are never both 1, and valid is 1 exactly when one of them is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0 | input | 1 | Half-rate in-phase clock; both edges sample bit centres; rising edge registers all outputs |
| clk90 | input | 1 | Half-rate clock a quarter period after `clk0`; both edges sample bit boundaries |
| rst_n | input | 1 | Synchronous active-low reset, sampled in every clock domain |
| ser_in | input | 1 | Serial line |
| bit_even | output | 1 | Demultiplexed even bit |
| bit_odd | output | 1 | Demultiplexed odd bit, aligned with `bit_even` |
| early | output | 2 | Per-lane clock-early decision (lane 0 = even-to-odd boundary) |
| late | output | 2 | Per-lane clock-late decision |
| valid | output | 2 | Per-lane flag that a decision was made |

## Verification
An even bit sampled at a `clk0` rising edge, the odd bit after it and the decisions for both following boundaries all become visible just after the second `clk0` rising edge after that sample. The bench keeps the bit array and the per-boundary offset (data late, data early, or a glitch) that it applied. It waits two rising edges after aligning the first even bit, then compares one bit pair and two decision lanes 0.5 ns after every `clk0` rising edge. That point lies before the next `clk90` edge. Line transitions are placed 0.5 ns before or after each boundary sample, or a short pulse is placed across it, so no sample falls on a changing input.

// File: rtl/hrpd_pkg.sv
// Package: shared types and the three-sample phase classifier.
// Assumes S0/S2 are bit-centre samples and S1 is the boundary sample between them.
package hrpd_pkg;

    localparam int LANES = 2;   // bits per half-rate clock period

    typedef enum logic [1:0] {
        PH_NONE  = 2'd0,
        PH_EARLY = 2'd1,
        PH_LATE  = 2'd2,
        PH_BAD   = 2'd3
    } phase_t;

    // Classify one boundary from its three samples.
    function automatic phase_t classify(input logic s0, input logic s1, input logic s2);
        logic lead_x;
        logic trail_x;
        lead_x  = s0 ^ s1;
        trail_x = s1 ^ s2;
        case ({lead_x, trail_x})
            2'b01:   return PH_EARLY;
            2'b10:   return PH_LATE;
            2'b11:   return PH_BAD;
            default: return PH_NONE;
        endcase
    endfunction

endpackage

// File: rtl/hrpd_edge_pair.sv
// Module: samples one input on both edges of one clock.
// Assumes the input is stable around both edges; synchronous active-low reset
// is applied in each edge's own domain.
module hrpd_edge_pair (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q_rise,
    output logic q_fall
);

    // Rising-edge sample.
    always_ff @(posedge clk) begin
        if (!rst_n) q_rise <= 1'b0;
        else        q_rise <= d;
    end

    // Falling-edge sample.
    always_ff @(negedge clk) begin
        if (!rst_n) q_fall <= 1'b0;
        else        q_fall <= d;
    end

endmodule

// File: rtl/hrpd_align.sv
// Module: moves the four samples of one period into the clk0 rising-edge domain.
// Assumes clk90 lags clk0 by a quarter period, so every source flop settles
// before the clk0 rising edge that captures it.
module hrpd_align (
    input  logic clk0,
    input  logic rst_n,
    input  logic ctr_rise,     // centre sample, clk0 rising
    input  logic ctr_fall,     // centre sample, clk0 falling
    input  logic bnd_rise,     // boundary sample, clk90 rising
    input  logic bnd_fall,     // boundary sample, clk90 falling
    output logic even_prev,    // even bit of the period being judged
    output logic odd_cur,      // odd bit of that period
    output logic bnd_a,        // boundary even->odd
    output logic bnd_b,        // boundary odd->next even
    output logic even_next     // following even bit
);

    // Retime the period's samples onto clk0 rising.
    always_ff @(posedge clk0) begin
        if (!rst_n) begin
            even_prev <= 1'b0;
            odd_cur   <= 1'b0;
            bnd_a     <= 1'b0;
            bnd_b     <= 1'b0;
        end else begin
            even_prev <= ctr_rise;
            odd_cur   <= ctr_fall;
            bnd_a     <= bnd_rise;
            bnd_b     <= bnd_fall;
        end
    end

    // The newest even sample already lives in the clk0 rising domain.
    always_comb even_next = ctr_rise;

endmodule

// File: rtl/hrpd_decide.sv
// Module: per-lane early/late decision and aligned data output.
// Assumes its inputs are all held in the clk0 rising-edge domain.
module hrpd_decide
    import hrpd_pkg::*;
(
    input  logic             clk0,
    input  logic             rst_n,
    input  logic [LANES-1:0] s0,
    input  logic [LANES-1:0] s1,
    input  logic [LANES-1:0] s2,
    input  logic             even_in,
    input  logic             odd_in,
    output logic             bit_even,
    output logic             bit_odd,
    output logic [LANES-1:0] early,
    output logic [LANES-1:0] late,
    output logic [LANES-1:0] valid
);

    // Register the demultiplexed pair together.
    always_ff @(posedge clk0) begin
        if (!rst_n) begin
            bit_even <= 1'b0;
            bit_odd  <= 1'b0;
        end else begin
            bit_even <= even_in;
            bit_odd  <= odd_in;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        phase_t ph;

        // Classify this lane's boundary.
        always_comb ph = classify(s0[g], s1[g], s2[g]);

        // Register the lane's flags.
        always_ff @(posedge clk0) begin
            if (!rst_n) begin
                early[g] <= 1'b0;
                late[g]  <= 1'b0;
                valid[g] <= 1'b0;
            end else begin
                early[g] <= (ph == PH_EARLY);
                late[g]  <= (ph == PH_LATE);
                valid[g] <= (ph == PH_EARLY) || (ph == PH_LATE);
            end
        end
    end

endmodule

// File: rtl/hrpd_top.sv
// Module: half-rate quadrature binary phase detector with 1:2 demultiplexing.
// Assumes clk90 is clk0 delayed by a quarter period, so clk0 edges land at bit
// centres and clk90 edges at bit boundaries. Outputs are registered on clk0 rising.
module hrpd_top
    import hrpd_pkg::*;
(
    input  logic             clk0,
    input  logic             clk90,
    input  logic             rst_n,
    input  logic             ser_in,
    output logic             bit_even,
    output logic             bit_odd,
    output logic [LANES-1:0] early,
    output logic [LANES-1:0] late,
    output logic [LANES-1:0] valid
);

    logic ctr_rise, ctr_fall, bnd_rise, bnd_fall;
    logic even_prev, odd_cur, bnd_a, bnd_b, even_next;
    logic [LANES-1:0] s0, s1, s2;

    hrpd_edge_pair u_ctr (
        .clk(clk0), .rst_n(rst_n), .d(ser_in),
        .q_rise(ctr_rise), .q_fall(ctr_fall)
    );

    hrpd_edge_pair u_bnd (
        .clk(clk90), .rst_n(rst_n), .d(ser_in),
        .q_rise(bnd_rise), .q_fall(bnd_fall)
    );

    hrpd_align u_align (
        .clk0(clk0), .rst_n(rst_n),
        .ctr_rise(ctr_rise), .ctr_fall(ctr_fall),
        .bnd_rise(bnd_rise), .bnd_fall(bnd_fall),
        .even_prev(even_prev), .odd_cur(odd_cur),
        .bnd_a(bnd_a), .bnd_b(bnd_b), .even_next(even_next)
    );

    // Lane 0: even->odd boundary; lane 1: odd->next even boundary.
    always_comb begin
        s0 = {odd_cur,   even_prev};
        s1 = {bnd_b,     bnd_a};
        s2 = {even_next, odd_cur};
    end

    hrpd_decide u_decide (
        .clk0(clk0), .rst_n(rst_n),
        .s0(s0), .s1(s1), .s2(s2),
        .even_in(even_prev), .odd_in(odd_cur),
        .bit_even(bit_even), .bit_odd(bit_odd),
        .early(early), .late(late), .valid(valid)
    );

endmodule

// File: rtl/hrpd_checks.sv
// Checker: properties on the phase detector's ports, bound to hrpd_top.
module hrpd_checks
    import hrpd_pkg::*;
(
    input logic             clk0,
    input logic             rst_n,
    input logic             bit_even,
    input logic             bit_odd,
    input logic [LANES-1:0] early,
    input logic [LANES-1:0] late,
    input logic [LANES-1:0] valid
);

    // Outputs clear after a reset edge.
    assert_reset_clear_R1: assert property (@(posedge clk0)
        !rst_n |=> (early == '0 && late == '0 && valid == '0 && !bit_even && !bit_odd));

    // Early and late never together.
    assert_exclusive_R8: assert property (@(posedge clk0) disable iff (!rst_n)
        (early & late) == '0);

    // Valid matches a decision in each lane.
    assert_valid_match_R8: assert property (@(posedge clk0) disable iff (!rst_n)
        valid == (early | late));

    // Equal even/odd bits leave lane 0 without a decision.
    assert_lane0_needs_edge_R6: assert property (@(posedge clk0) disable iff (!rst_n)
        (bit_even == bit_odd) |-> !valid[0]);

    // A lane 1 decision implies the next even bit differs from this odd bit.
    assert_lane1_edge_R3: assert property (@(posedge clk0) disable iff (!rst_n)
        valid[1] |=> (bit_even != $past(bit_odd)));

endmodule

bind hrpd_top hrpd_checks u_checks (
    .clk0(clk0), .rst_n(rst_n),
    .bit_even(bit_even), .bit_odd(bit_odd),
    .early(early), .late(late), .valid(valid)
);

// File: tb/sim_hrpd_top.sv
`timescale 1ns/1ps
module sim_hrpd_top;

    localparam int NB = 400;

    logic       clk0 = 1'b0;
    logic       clk90 = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       bit_even, bit_odd;
    logic [1:0] early, late, valid;

    int  n_chk = 0;
    int  n_bad = 0;
    logic bits [0:NB-1];
    int  mode [0:NB-1];   // boundary into bit k: 0 data early (clock late), 1 data late (clock early), 2 glitch
    real t0;

    hrpd_top u0 (
        .clk0(clk0), .clk90(clk90), .rst_n(rst_n), .ser_in(ser_in),
        .bit_even(bit_even), .bit_odd(bit_odd),
        .early(early), .late(late), .valid(valid)
    );

    always #2 clk0 = ~clk0;
    initial begin
        #1;
        forever #2 clk90 = ~clk90;
    end

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $realtime);
        end
    endtask

    // Expected {valid,late,early} for the boundary into bit j.
    function automatic int exp_dec(input int j);
        logic diff;
        diff = bits[j-1] ^ bits[j];
        if (mode[j] == 2) return 0;            // R7 glitch
        if (!diff) return 0;                   // R6 no transition
        if (mode[j] == 1) return 3'b101;       // R4 early
        return 3'b110;                         // R5 late
    endfunction

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < NB; k++) begin
            if (k < 40) begin
                bits[k] = k[0];  mode[k] = 1;              // alternating, clock early
            end else if (k < 80) begin
                bits[k] = k[0];  mode[k] = 0;              // alternating, clock late
            end else if (k < 120) begin
                bits[k] = k[3];                            // runs of eight
                mode[k] = (k % 3 == 0) ? 2 : 1;
            end else begin
                bits[k] = $urandom() % 2;
                mode[k] = $urandom() % 2;
            end
        end
        for (int k = 1; k < NB; k++)
            if (mode[k] == 2 && bits[k] != bits[k-1]) mode[k] = 0;
        for (int k = 120; k < NB; k++)
            if (bits[k] == bits[k-1] && ($urandom() % 5 == 0)) mode[k] = 2;

        // Reset phase
        repeat (4) @(posedge clk0);
        #0.5;
        chk("R1 early", int'(early), 0);
        chk("R1 late", int'(late), 0);
        chk("R1 valid", int'(valid), 0);
        chk("R1 data", int'({bit_even, bit_odd}), 0);
        @(negedge clk0); #0.5;
        rst_n = 1'b1;
        repeat (3) @(posedge clk0);

        @(negedge clk0);
        ser_in = bits[0];
        @(posedge clk0);
        t0 = $realtime;
        fork
            begin : drive
                for (int k = 1; k < NB; k++) begin
                    real tt;
                    tt = t0 + 2.0 * k - 1.0;
                    if (mode[k] == 2) begin
                        #(tt - 0.2 - $realtime);
                        ser_in = ~bits[k-1];
                        #0.4;
                        ser_in = bits[k];
                    end else begin
                        #(tt + ((mode[k] == 1) ? 0.5 : -0.5) - $realtime);
                        ser_in = bits[k];
                    end
                end
            end
            begin : watch
                repeat (2) @(posedge clk0);
                for (int m = 0; m <= NB/2 - 2; m++) begin
                    int d0, d1;
                    if (m > 0) @(posedge clk0);
                    #0.5;
                    d0 = exp_dec(2*m + 1);
                    d1 = exp_dec(2*m + 2);
                    chk("R2 even", int'(bit_even), int'(bits[2*m]));
                    chk("R2 odd", int'(bit_odd), int'(bits[2*m+1]));
                    chk("R3 lane0 R4 R5 R6 R7", int'({valid[0], late[0], early[0]}), d0);
                    chk("R3 lane1 R4 R5 R6 R7", int'({valid[1], late[1], early[1]}), d1);
                    chk("R8", int'((early & late) != 0 || valid != (early | late)), 0);
                end
            end
        join
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule